// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block is a purely combinational front end for a double-precision fused multiply-add unit computing an addend plus or minus a product. It looks at the three 64-bit operands (addend `op_z`, multiplicands `op_x` and `op_y`) and decides whether the result follows from operand classes alone: a NaN is present, the product or the addend is infinite, or the product is zero. When it can decide, it raises `special_valid`, drives the final word on `special_result` and reports an invalid operation where one arises. When it cannot, `special_valid` stays low and the arithmetic datapath owns the result.

Two sign controls choose among the four instruction variants: `neg_prod` negates the product and `neg_addend` negates the addend. The rounding mode input matters only for the sign of an exact zero sum. Subnormal operands count as finite nonzero values; their normalisation, the arithmetic and the rounding all happen elsewhere.

Top module: `fma_special_resolver`

## Requirements
- R1: The effective product sign is op_x[63] XOR op_y[63] XOR neg_prod; the effective addend sign is op_z[63] XOR neg_addend. The four variants are all four combinations of the two flags.
- R2: Operand classes: exponent field [62:52] all ones with fraction [51:0] zero is infinity; all ones with nonzero fraction is a NaN, quiet when bit 51 is 1 and signaling when it is 0; exponent and fraction both zero is zero. NaN selection order is signaling in z, x, y, then quiet in z, x, y.
- R3: A selected signaling NaN is returned with bit 51 set and all other bits kept, and invalid_op is 1.
- R4: A selected quiet NaN is returned bit for bit unchanged, and invalid_op is 0.
- R5: Infinity times zero in either order, with no NaN present, gives DEFAULT_NAN (0x7FF8000000000000 by default) with invalid_op 1.
- R6: An infinite product with an infinite addend of opposite effective sign gives DEFAULT_NAN with invalid_op 1.
- R7: Any other infinite product gives infinity with the effective product sign.
- R8: A finite product (operands zero, subnormal or normal) with an infinite addend gives infinity with the effective addend sign.
- R9: A zero product with a zero addend of the same effective sign gives zero of that sign.
- R10: A zero product with a zero addend of differing effective sign gives +0, except when rnd_mode is 2'b11 (toward minus infinity; 00 nearest, 01 toward zero, 10 toward plus infinity) where it gives -0.
- R11: A zero product with a finite nonzero addend gives the addend magnitude with the effective addend sign.
- R12: When no case above applies, special_valid, invalid_op and special_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 64 | Addend operand |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Negate the product |
| neg_addend | input | 1 | Negate the addend |
| rnd_mode | input | 2 | Rounding mode, 2'b11 is toward minus infinity |
| special_valid | output | 1 | Result is decided here |
| special_result | output | 64 | Decided result word |
| invalid_op | output | 1 | Invalid operation raised |

## Verification
Directed vectors pair NaNs of both kinds in different operand slots so that the selection order, quieting and payload retention are told apart, and set infinities against zeros and against each other under every flag combination to separate the cancellation case from the plain infinite result. Zero-sum vectors sweep all four rounding modes to isolate the one mode that flips the sign. A seeded random stream draws each operand from weighted class buckets with random signs and flags, which reaches the mixed-class combinations and the non-special fall-through that the directed cases only sample.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;

  localparam int unsigned EXP_W     = 11;
  localparam int unsigned FRAC_W    = 52;
  localparam int unsigned WORD_W    = 1 + EXP_W + FRAC_W;
  localparam int unsigned QUIET_BIT = FRAC_W - 1;
  localparam int unsigned NUM_OPS   = 3;
  localparam int unsigned IDX_Z     = 0;
  localparam int unsigned IDX_X     = 1;
  localparam int unsigned IDX_Y     = 2;

  localparam logic [1:0] RM_NEAREST = 2'b00;
  localparam logic [1:0] RM_TOZERO  = 2'b01;
  localparam logic [1:0] RM_UP      = 2'b10;
  localparam logic [1:0] RM_DOWN    = 2'b11;

  typedef logic [WORD_W-1:0] fp_word_t;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } op_class_e;

  function automatic logic sign_of(fp_word_t w);
    return w[WORD_W-1];
  endfunction

  function automatic logic [EXP_W-1:0] exp_of(fp_word_t w);
    return w[WORD_W-2 -: EXP_W];
  endfunction

  function automatic logic [FRAC_W-1:0] frac_of(fp_word_t w);
    return w[FRAC_W-1:0];
  endfunction

  function automatic op_class_e classify(fp_word_t w);
    logic exp_max;
    logic exp_min;
    logic frac_nz;
    exp_max = &exp_of(w);
    exp_min = ~|exp_of(w);
    frac_nz = |frac_of(w);
    if (exp_max) begin
      if (!frac_nz)         return CL_INF;
      else if (w[QUIET_BIT]) return CL_QNAN;
      else                   return CL_SNAN;
    end
    if (exp_min) return frac_nz ? CL_SUB : CL_ZERO;
    return CL_NORM;
  endfunction

  function automatic fp_word_t inf_word(logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic fp_word_t zero_word(logic s);
    return {s, {(WORD_W-1){1'b0}}};
  endfunction

  function automatic fp_word_t quieten(fp_word_t w);
    fp_word_t r;
    r = w;
    r[QUIET_BIT] = 1'b1;
    return r;
  endfunction

  function automatic fp_word_t with_sign(fp_word_t w, logic s);
    fp_word_t r;
    r = w;
    r[WORD_W-1] = s;
    return r;
  endfunction

endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
(
  input  fp_word_t  word_i,
  output op_class_e class_o,
  output logic      sign_o
);

  assign class_o = classify(word_i);
  assign sign_o  = sign_of(word_i);

endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
  import fma_sc_pkg::*;
#(
  parameter int unsigned N = NUM_OPS
) (
  input  fp_word_t  words_i [N],
  input  op_class_e cls_i   [N],
  output logic      hit_o,
  output logic      signaling_o,
  output fp_word_t  result_o
);

  logic [N-1:0] snan_v;
  logic [N-1:0] qnan_v;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign snan_v[i] = (cls_i[i] == CL_SNAN);
    assign qnan_v[i] = (cls_i[i] == CL_QNAN);
  end

  // Lower index wins; signaling of any slot outranks quiet of any slot.
  always_comb begin
    hit_o       = 1'b0;
    signaling_o = 1'b0;
    result_o    = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (qnan_v[i]) begin
        hit_o    = 1'b1;
        result_o = words_i[i];
      end
    end
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (snan_v[i]) begin
        hit_o       = 1'b1;
        signaling_o = 1'b1;
        result_o    = quieten(words_i[i]);
      end
    end
  end

endmodule

// File: rtl/fma_sc_inf_zero.sv
module fma_sc_inf_zero
  import fma_sc_pkg::*;
#(
  parameter fp_word_t DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
  input  op_class_e  z_cls,
  input  op_class_e  x_cls,
  input  op_class_e  y_cls,
  input  logic       prod_sign,
  input  logic       addend_sign,
  input  fp_word_t   z_word,
  input  logic [1:0] rnd_mode,
  output logic       hit_o,
  output logic       invalid_o,
  output fp_word_t   result_o,
  output logic       inf_x_zero_o,
  output logic       inf_clash_o,
  output logic       prod_inf_o,
  output logic       prod_zero_o
);

  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

  assign x_inf  = (x_cls == CL_INF);
  assign y_inf  = (y_cls == CL_INF);
  assign x_zero = (x_cls == CL_ZERO);
  assign y_zero = (y_cls == CL_ZERO);
  assign z_inf  = (z_cls == CL_INF);
  assign z_zero = (z_cls == CL_ZERO);

  assign inf_x_zero_o = (x_inf & y_zero) | (x_zero & y_inf);
  assign prod_inf_o   = (x_inf | y_inf) & ~inf_x_zero_o;
  assign prod_zero_o  = (x_zero | y_zero) & ~inf_x_zero_o;
  assign inf_clash_o  = prod_inf_o & z_inf & (addend_sign != prod_sign);

  always_comb begin
    hit_o     = 1'b0;
    invalid_o = 1'b0;
    result_o  = '0;
    if (inf_x_zero_o || inf_clash_o) begin
      hit_o     = 1'b1;
      invalid_o = 1'b1;
      result_o  = DEFAULT_NAN;
    end else if (prod_inf_o) begin
      hit_o    = 1'b1;
      result_o = inf_word(prod_sign);
    end else if (z_inf) begin
      hit_o    = 1'b1;
      result_o = inf_word(addend_sign);
    end else if (prod_zero_o) begin
      hit_o = 1'b1;
      if (z_zero) begin
        if (addend_sign == prod_sign) result_o = zero_word(addend_sign);
        else                          result_o = zero_word(rnd_mode == RM_DOWN);
      end else begin
        result_o = with_sign(z_word, addend_sign);
      end
    end
  end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_sc_pkg::*;
#(
  parameter fp_word_t DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
  input  logic [63:0] op_z,
  input  logic [63:0] op_x,
  input  logic [63:0] op_y,
  input  logic        neg_prod,
  input  logic        neg_addend,
  input  logic [1:0]  rnd_mode,
  output logic        special_valid,
  output logic [63:0] special_result,
  output logic        invalid_op
);

  fp_word_t  ops [NUM_OPS];
  op_class_e cls [NUM_OPS];
  logic      sgn [NUM_OPS];

  assign ops[IDX_Z] = op_z;
  assign ops[IDX_X] = op_x;
  assign ops[IDX_Y] = op_y;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
    fma_sc_classify u_cls (
      .word_i (ops[i]),
      .class_o(cls[i]),
      .sign_o (sgn[i])
    );
  end

  logic prod_sign;
  logic addend_sign;
  assign prod_sign   = sgn[IDX_X] ^ sgn[IDX_Y] ^ neg_prod;
  assign addend_sign = sgn[IDX_Z] ^ neg_addend;

  logic     nan_hit;
  logic     nan_signaling;
  fp_word_t nan_result;

  fma_sc_nan_pick #(.N(NUM_OPS)) u_nan (
    .words_i    (ops),
    .cls_i      (cls),
    .hit_o      (nan_hit),
    .signaling_o(nan_signaling),
    .result_o   (nan_result)
  );

  logic     iz_hit;
  logic     iz_invalid;
  fp_word_t iz_result;
  logic     inf_x_zero;
  logic     inf_clash;
  logic     prod_inf;
  logic     prod_zero;

  fma_sc_inf_zero #(.DEFAULT_NAN(DEFAULT_NAN)) u_iz (
    .z_cls       (cls[IDX_Z]),
    .x_cls       (cls[IDX_X]),
    .y_cls       (cls[IDX_Y]),
    .prod_sign   (prod_sign),
    .addend_sign (addend_sign),
    .z_word      (op_z),
    .rnd_mode    (rnd_mode),
    .hit_o       (iz_hit),
    .invalid_o   (iz_invalid),
    .result_o    (iz_result),
    .inf_x_zero_o(inf_x_zero),
    .inf_clash_o (inf_clash),
    .prod_inf_o  (prod_inf),
    .prod_zero_o (prod_zero)
  );

  always_comb begin
    if (nan_hit) begin
      special_valid  = 1'b1;
      special_result = nan_result;
      invalid_op     = nan_signaling;
    end else begin
      special_valid  = iz_hit;
      special_result = iz_result;
      invalid_op     = iz_invalid;
    end
  end

endmodule

// File: rtl/fma_sc_checker.sv
module fma_sc_checker
  import fma_sc_pkg::*;
#(
  parameter fp_word_t DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
  input logic [63:0] op_z,
  input logic [63:0] op_x,
  input logic [63:0] op_y,
  input logic        neg_prod,
  input logic        neg_addend,
  input logic        special_valid,
  input logic [63:0] special_result,
  input logic        invalid_op,
  input logic        nan_hit,
  input logic        inf_x_zero,
  input logic        inf_clash,
  input logic        prod_inf
);

  logic any_snan;
  logic port_prod_sign;
  assign any_snan = (classify(op_z) == CL_SNAN) || (classify(op_x) == CL_SNAN)
                 || (classify(op_y) == CL_SNAN);
  assign port_prod_sign = op_x[63] ^ op_y[63] ^ neg_prod;

  always_comb begin
    if (!special_valid)
      assert_idle_quiet_R12: assert (special_result == '0 && !invalid_op)
        else $error("idle outputs not zero");
    if (invalid_op)
      assert_invalid_has_valid_R5: assert (special_valid)
        else $error("invalid without valid");
    if (any_snan)
      assert_snan_quieted_R3: assert (invalid_op && nan_hit && special_result[QUIET_BIT]
                                      && (&special_result[62:52]))
        else $error("signaling NaN not quieted");
    if (nan_hit && !any_snan)
      assert_qnan_silent_R4: assert (!invalid_op
                                     && (special_result == op_z || special_result == op_x
                                         || special_result == op_y))
        else $error("quiet NaN altered");
    if (inf_x_zero && !nan_hit)
      assert_inf_times_zero_R5: assert (invalid_op && special_result == DEFAULT_NAN)
        else $error("inf times zero not invalid");
    if (inf_clash && !nan_hit)
      assert_inf_cancel_R6: assert (invalid_op && special_result == DEFAULT_NAN)
        else $error("inf cancellation not invalid");
    if (prod_inf && !inf_clash && !nan_hit)
      assert_inf_product_R7: assert (special_result == inf_word(port_prod_sign) && !invalid_op)
        else $error("infinite product wrong");
  end

endmodule

bind fma_special_resolver fma_sc_checker #(.DEFAULT_NAN(DEFAULT_NAN)) u_checker (
  .op_z          (op_z),
  .op_x          (op_x),
  .op_y          (op_y),
  .neg_prod      (neg_prod),
  .neg_addend    (neg_addend),
  .special_valid (special_valid),
  .special_result(special_result),
  .invalid_op    (invalid_op),
  .nan_hit       (nan_hit),
  .inf_x_zero    (inf_x_zero),
  .inf_clash     (inf_clash),
  .prod_inf      (prod_inf)
);

// File: tb/fma_special_resolver_bench.sv
`timescale 1ns/1ps
module fma_special_resolver_bench;

  localparam logic [63:0] DNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] PZERO = 64'h0;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] ONE5  = 64'h3FF8_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] THREE = 64'h4008_0000_0000_0000;
  localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0ABC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] op_z, op_x, op_y;
  logic        neg_prod, neg_addend;
  logic [1:0]  rnd_mode;
  logic        special_valid, invalid_op;
  logic [63:0] special_result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fma_special_resolver u_fma_special_resolver (
    .op_z(op_z), .op_x(op_x), .op_y(op_y),
    .neg_prod(neg_prod), .neg_addend(neg_addend), .rnd_mode(rnd_mode),
    .special_valid(special_valid), .special_result(special_result), .invalid_op(invalid_op)
  );

  function automatic bit f_isnan(logic [63:0] w);
    return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
  endfunction
  function automatic bit f_snan(logic [63:0] w);
    return f_isnan(w) && !w[51];
  endfunction
  function automatic bit f_inf(logic [63:0] w);
    return (w[62:52] == 11'h7FF) && (w[51:0] == 0);
  endfunction
  function automatic bit f_zero(logic [63:0] w);
    return w[62:0] == 0;
  endfunction

  // Returns {valid, invalid, result}
  function automatic logic [65:0] model(logic [63:0] z, logic [63:0] x, logic [63:0] y,
                                        logic np, logic na, logic [1:0] rm);
    logic ps, zs;
    if (f_snan(z)) return {2'b11, z | (64'd1 << 51)};
    if (f_snan(x)) return {2'b11, x | (64'd1 << 51)};
    if (f_snan(y)) return {2'b11, y | (64'd1 << 51)};
    if (f_isnan(z)) return {2'b10, z};
    if (f_isnan(x)) return {2'b10, x};
    if (f_isnan(y)) return {2'b10, y};
    ps = x[63] ^ y[63] ^ np;
    zs = z[63] ^ na;
    if ((f_inf(x) && f_zero(y)) || (f_zero(x) && f_inf(y))) return {2'b11, DNAN};
    if (f_inf(x) || f_inf(y)) begin
      if (f_inf(z) && zs != ps) return {2'b11, DNAN};
      return {2'b10, ps, 63'h7FF0_0000_0000_0000};
    end
    if (f_inf(z)) return {2'b10, zs, 63'h7FF0_0000_0000_0000};
    if (f_zero(x) || f_zero(y)) begin
      if (f_zero(z)) begin
        if (zs == ps) return {2'b10, zs, 63'h0};
        return {2'b10, (rm == 2'b11), 63'h0};
      end
      return {2'b10, zs, z[62:0]};
    end
    return 66'h0;
  endfunction

  task automatic apply(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y,
                       input logic np, input logic na, input logic [1:0] rm, input string tag);
    logic [65:0] exp_v, act_v;
    @(negedge clk);
    op_z = z; op_x = x; op_y = y;
    neg_prod = np; neg_addend = na; rnd_mode = rm;
    #1;
    exp_v = model(z, x, y, np, na, rm);
    act_v = {special_valid, invalid_op, special_result};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual v=%b i=%b r=%h expected v=%b i=%b r=%h", tag,
               act_v[65], act_v[64], act_v[63:0], exp_v[65], exp_v[64], exp_v[63:0]);
    end
  endtask

  function automatic logic [63:0] gen_op();
    int unsigned k;
    logic s;
    logic [51:0] f;
    k = $urandom % 16;
    s = 1'($urandom);
    f = {20'($urandom), 32'($urandom)};
    if (k < 3)  return {s, 63'h0};
    if (k < 5)  return {s, 11'h0, (f == 0) ? 52'd1 : f};
    if (k < 10) return {s, 11'(1 + ($urandom % 2046)), f};
    if (k < 13) return {s, 11'h7FF, 52'h0};
    if (k < 15) return {s, 11'h7FF, 1'b1, f[50:0]};
    return {s, 11'h7FF, 1'b0, (f[50:0] == 0) ? 51'd5 : f[50:0]};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // Initial state: all-zero inputs give +0 (R9)
    apply(PZERO, PZERO, PZERO, 0, 0, 2'b00, "init R9");
    // NaN priority R2
    apply(64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0002, ONE, 0, 0, 0, "R2 snan z over snan x");
    apply(64'h7FF8_0000_0000_0011, 64'h7FF0_0000_0000_0022, ONE, 0, 0, 0, "R2 snan x over qnan z");
    apply(ONE, 64'h7FF8_0000_0000_0033, 64'hFFF8_0000_0000_0044, 0, 0, 0, "R2 qnan x over qnan y");
    apply(ONE, 64'h7FF8_0000_0000_0033, 64'hFFF0_0000_0000_0044, 0, 0, 0, "R2 snan y over qnan x");
    // R3 / R4
    apply(ONE, TWO, 64'hFFF0_0000_0000_0123, 1, 1, 0, "R3 snan y quieted");
    apply(64'hFFF8_0000_0000_0ABC, PINF, PZERO, 0, 0, 0, "R4 qnan z unchanged");
    // R5
    apply(ONE, PINF, PZERO, 0, 0, 0, "R5 inf*0");
    apply(NINF, NZERO, PINF, 1, 0, 0, "R5 0*inf");
    // R6 / R1
    apply(NINF, PINF, TWO, 0, 0, 0, "R6 inf minus inf");
    apply(PINF, PINF, TWO, 0, 1, 0, "R6 R1 negated addend cancels");
    apply(PINF, PINF, TWO, 0, 0, 0, "R7 same sign inf");
    // R7 / R1
    apply(THREE, NINF, TWO, 0, 0, 0, "R7 neg inf product");
    apply(THREE, NINF, TWO, 1, 0, 0, "R7 R1 negated product");
    apply(PINF, NINF, NINF, 0, 0, 0, "R7 inf*inf");
    // R8
    apply(NINF, TWO, THREE, 0, 0, 0, "R8 finite product z inf");
    apply(NINF, TWO, THREE, 0, 1, 0, "R8 R1 negated addend inf");
    apply(PINF, SUBN, PZERO, 1, 0, 0, "R8 zero product z inf");
    // R9
    apply(NZERO, NZERO, ONE, 0, 0, 0, "R9 both negative zero");
    apply(PZERO, NZERO, ONE, 1, 0, 1, "R9 R1 negated product matches");
    // R10
    for (int m = 0; m < 4; m++)
      apply(PZERO, NZERO, ONE, 0, 0, 2'(m), "R10 differing zeros");
    apply(PZERO, PZERO, ONE, 0, 1, 2'b11, "R10 R1 negated addend differs");
    // R11
    apply(ONE5, PZERO, THREE, 0, 0, 0, "R11 z passes");
    apply(ONE5, PZERO, THREE, 0, 1, 0, "R11 R1 z negated");
    apply(SUBN, TWO, NZERO, 1, 1, 0, "R11 subnormal z");
    // R12
    apply(ONE, TWO, THREE, 0, 0, 0, "R12 all normal");
    apply(SUBN, SUBN, SUBN, 1, 1, 3, "R12 all subnormal");
    // Random mix
    for (int n = 0; n < 4000; n++)
      apply(gen_op(), gen_op(), gen_op(), 1'($urandom), 1'($urandom), 2'($urandom),
            "random R1 R2 R5 R6 R7 R8 R9 R10 R11 R12");
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule